// File: doc/BRIEF.md
# Transmit Descriptor Ring Engine

The engine walks a ring of transmit descriptors kept in a word-addressed memory that it shares with software. Software fills a frame buffer, writes the descriptor's length and buffer address, and then sets its ready bit. The engine fetches that descriptor and sends the frame bytes one at a time to the MAC-side byte stream, marking the first byte and the last byte. After the last byte it writes the descriptor back with the ready bit cleared. Software watches that bit to learn that the frame has gone out. The append-CRC request in the descriptor is not acted on here. It is passed along with every byte of the frame for the MAC to use.

The engine comes out of reset halted. It stays halted until software issues a clear-halt register write on `clr_halt_i`. After that write it keeps polling descriptors in ring order. It halts again when it meets a descriptor that is not ready, and it keeps its place in the ring so that the next clear-halt resumes at that same descriptor. A descriptor carrying the wrap bit sends the engine back to the ring base. A graceful stop request lets any frame in flight finish, keeps the engine away from new descriptors, and raises a sticky stop-complete flag.

Descriptor *i* occupies words `RING_BASE + 2*i` (word 0) and `RING_BASE + 2*i + 1` (word 1). Memory reads return their data one cycle after `mem_rd_en_o`. Writes take effect at the clock edge where `mem_wr_en_o` is high.

Top module: `tbd_tx_engine`

## Requirements
- R1: Out of reset, `halted_o` is 1, `stop_done_o` is 0, `tx_valid_o` is 0, no memory read or write is issued, and the ring position is descriptor 0.
- R2: While halted, the engine reads nothing and ignores ready descriptors until a one-cycle `clr_halt_i` strobe. The strobe restarts polling at the current ring position.
- R3: Word 0 of a descriptor holds the status field in bits 31:16 and the byte length in bits 15:0. The status bits are ready (bit 31), wrap (bit 30), raise-done (bit 29) and append-CRC (bit 28). The low `AW` bits of word 1 are the word address of the frame buffer. The engine acts only on a descriptor whose ready bit is 1.
- R4: A frame puts out exactly `length` bytes with `tx_valid_o` high. The bytes come from consecutive buffer words, least significant byte first. `tx_sof_o` is high on the first byte only and `tx_eof_o` on the last byte only. `tx_crc_o` equals the descriptor's append-CRC bit on every byte.
- R5: After the last byte, word 0 is written back with bit 31 cleared and all other bits unchanged. A descriptor that is not ready is never written.
- R6: `tx_done_o` pulses for exactly one cycle, together with the write-back, for each descriptor whose raise-done bit is set. It stays low for any other descriptor.
- R7: After a descriptor with the wrap bit set, the next poll reads descriptor 0. Otherwise it reads the following descriptor.
- R8: When the engine polls a descriptor whose ready bit is clear, it sets `halted_o` and keeps that descriptor as its position.
- R9: A ready descriptor of length 0 produces no bytes but is still written back, with its done pulse if requested.
- R10: While `stop_req_i` is high, a frame already started completes but no further descriptor is read. `stop_done_o` sets once the engine is between frames, whether it is running or halted.
- R11: `stop_done_o` stays 1 until a `stop_clr_i` strobe while the request is low. While the engine is quiet with the request high, the flag is set again.
- R12: A clear-halt strobe while `stop_req_i` is high leaves the engine without fetching. It resumes polling when the request drops.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_halt_i | input | 1 | Clear-halt register write strobe |
| stop_req_i | input | 1 | Graceful stop request (level) |
| stop_clr_i | input | 1 | Write-one-to-clear strobe for the stop-complete flag |
| mem_rd_en_o | output | 1 | Memory read request |
| mem_wr_en_o | output | 1 | Descriptor write-back strobe |
| mem_addr_o | output | AW | Word address for the read or write |
| mem_wdata_o | output | 32 | Write-back data |
| mem_rdata_i | input | 32 | Read data, valid one cycle after the request |
| tx_valid_o | output | 1 | Byte valid |
| tx_data_o | output | 8 | Frame byte |
| tx_sof_o | output | 1 | First byte of the frame |
| tx_eof_o | output | 1 | Last byte of the frame |
| tx_crc_o | output | 1 | Append-CRC request of the current frame |
| tx_done_o | output | 1 | One-cycle completion pulse |
| halted_o | output | 1 | Transmit-halted status |
| stop_done_o | output | 1 | Sticky stop-complete event |

## Verification
The bench aims at frame lengths that are not a multiple of four and at frames longer than one word. An engine that miscounts bytes or unpacks them in the wrong order would add, drop or swap bytes there. It also goes through the wrap descriptor and a descriptor that is not ready. A wrong wrap would send the next frame from the wrong buffer, and a faulty halt would overwrite or transmit a descriptor that software still owns. A zero-length descriptor checks that write-back happens without any byte. A stop requested in the middle of a frame, and a stop requested while halted and then followed by a clear-halt, check that the stop neither cuts the current frame short nor lets the next descriptor start early. They also check that the stop-complete flag holds until it is cleared.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int unsigned LEN_W      = 16;
  localparam int unsigned DESC_WORDS = 2;
  // word-0 bit positions, shared with software
  localparam int unsigned B_READY = 31;
  localparam int unsigned B_WRAP  = 30;
  localparam int unsigned B_IRQ   = 29;
  localparam int unsigned B_CRC   = 28;

  typedef enum logic [3:0] {
    S_HALT, S_POLL, S_W0, S_W1, S_RD, S_LD, S_EMIT, S_WB, S_STOP
  } tbd_state_e;
endpackage

// File: rtl/tbd_ring_ptr.sv
module tbd_ring_ptr #(
  parameter int unsigned AW        = 10,
  parameter int unsigned RING_BASE = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  input  logic          wrap_i,
  output logic [AW-1:0] ptr_o
);
  localparam logic [AW-1:0] BASE = AW'(RING_BASE);
  localparam logic [AW-1:0] STEP = AW'(tbd_pkg::DESC_WORDS);

  logic [AW-1:0] ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     ptr_q <= BASE;
    else if (adv_i)  ptr_q <= wrap_i ? BASE : ptr_q + STEP;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/tbd_byte_unpack.sv
module tbd_byte_unpack #(
  parameter int unsigned LW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          len_ld_i,
  input  logic [LW-1:0] len_i,
  input  logic          word_ld_i,
  input  logic [31:0]   word_i,
  input  logic          step_i,
  output logic [7:0]    byte_o,
  output logic          first_o,
  output logic          last_o,
  output logic          word_end_o
);
  logic [31:0]   word_q;
  logic [LW-1:0] rem_q;
  logic [1:0]    idx_q;
  logic          first_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      word_q  <= '0;
      rem_q   <= '0;
      idx_q   <= '0;
      first_q <= 1'b0;
    end else begin
      if (len_ld_i) begin
        rem_q   <= len_i;
        idx_q   <= '0;
        first_q <= 1'b1;
      end else if (step_i) begin
        rem_q   <= rem_q - LW'(1);
        idx_q   <= idx_q + 2'd1;
        first_q <= 1'b0;
      end
      if (word_ld_i)   word_q <= word_i;
      else if (step_i) word_q <= {8'h00, word_q[31:8]};
    end
  end

  assign byte_o     = word_q[7:0];
  assign first_o    = first_q;
  assign last_o     = (rem_q == LW'(1));
  assign word_end_o = (idx_q == 2'd3);
endmodule

// File: rtl/tbd_ctrl.sv
module tbd_ctrl
  import tbd_pkg::*;
#(
  parameter int unsigned AW = 10
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_halt_i,
  input  logic             stop_req_i,
  input  logic             stop_clr_i,
  input  logic [31:0]      mem_rdata_i,
  input  logic [AW-1:0]    ptr_i,
  input  logic             last_i,
  input  logic             word_end_i,
  output logic             mem_rd_en_o,
  output logic             mem_wr_en_o,
  output logic [AW-1:0]    mem_addr_o,
  output logic [31:0]      mem_wdata_o,
  output logic             adv_o,
  output logic             wrap_o,
  output logic             len_ld_o,
  output logic [LEN_W-1:0] len_o,
  output logic             word_ld_o,
  output logic             step_o,
  output logic             emit_o,
  output logic             crc_o,
  output logic             done_o,
  output logic             halted_o,
  output logic             stop_done_o
);
  tbd_state_e    state_q, state_d;
  logic [31:0]   desc_q;
  logic [AW-1:0] daddr_q;
  logic          stop_done_q;
  logic          quiet;

  always_comb begin
    state_d     = state_q;
    mem_rd_en_o = 1'b0;
    mem_wr_en_o = 1'b0;
    mem_addr_o  = ptr_i;
    mem_wdata_o = desc_q;
    adv_o       = 1'b0;
    len_ld_o    = 1'b0;
    word_ld_o   = 1'b0;
    step_o      = 1'b0;
    done_o      = 1'b0;
    unique case (state_q)
      S_HALT: if (clr_halt_i) state_d = S_POLL;
      S_POLL: begin
        if (stop_req_i) state_d = S_STOP;
        else begin
          mem_rd_en_o = 1'b1;
          state_d     = S_W0;
        end
      end
      S_W0: begin
        if (mem_rdata_i[B_READY]) begin
          mem_rd_en_o = 1'b1;
          mem_addr_o  = ptr_i + AW'(1);
          len_ld_o    = 1'b1;
          state_d     = S_W1;
        end else begin
          state_d = S_HALT;
        end
      end
      S_W1: state_d = (desc_q[LEN_W-1:0] == '0) ? S_WB : S_RD;
      S_RD: begin
        mem_rd_en_o = 1'b1;
        mem_addr_o  = daddr_q;
        state_d     = S_LD;
      end
      S_LD: begin
        word_ld_o = 1'b1;
        state_d   = S_EMIT;
      end
      S_EMIT: begin
        step_o = 1'b1;
        if (last_i)          state_d = S_WB;
        else if (word_end_i) state_d = S_RD;
      end
      S_WB: begin
        mem_wr_en_o         = 1'b1;
        mem_wdata_o[B_READY] = 1'b0;
        done_o              = desc_q[B_IRQ];
        adv_o               = 1'b1;
        state_d             = S_POLL;
      end
      S_STOP: if (!stop_req_i) state_d = S_POLL;
      default: state_d = S_HALT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= S_HALT;
      desc_q  <= '0;
      daddr_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == S_W0) desc_q  <= mem_rdata_i;
      if (state_q == S_W1) daddr_q <= mem_rdata_i[AW-1:0];
      else if (state_q == S_RD) daddr_q <= daddr_q + AW'(1);
    end
  end

  // set wins over clear while still quiet under request
  assign quiet = (state_q == S_HALT) || (state_q == S_STOP);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  stop_done_q <= 1'b0;
    else if (quiet && stop_req_i) stop_done_q <= 1'b1;
    else if (stop_clr_i)          stop_done_q <= 1'b0;
  end

  assign len_o       = mem_rdata_i[LEN_W-1:0];
  assign wrap_o      = desc_q[B_WRAP];
  assign crc_o       = desc_q[B_CRC];
  assign emit_o      = (state_q == S_EMIT);
  assign halted_o    = (state_q == S_HALT);
  assign stop_done_o = stop_done_q;
endmodule

// File: rtl/tbd_tx_engine.sv
module tbd_tx_engine #(
  parameter int unsigned AW        = 10,
  parameter int unsigned RING_BASE = 0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_halt_i,
  input  logic          stop_req_i,
  input  logic          stop_clr_i,
  output logic          mem_rd_en_o,
  output logic          mem_wr_en_o,
  output logic [AW-1:0] mem_addr_o,
  output logic [31:0]   mem_wdata_o,
  input  logic [31:0]   mem_rdata_i,
  output logic          tx_valid_o,
  output logic [7:0]    tx_data_o,
  output logic          tx_sof_o,
  output logic          tx_eof_o,
  output logic          tx_crc_o,
  output logic          tx_done_o,
  output logic          halted_o,
  output logic          stop_done_o
);
  import tbd_pkg::*;

  logic [AW-1:0]    ptr;
  logic             adv, wrap;
  logic             len_ld, word_ld, step, emit;
  logic [LEN_W-1:0] len;
  logic             first, last, word_end;

  tbd_ring_ptr #(.AW(AW), .RING_BASE(RING_BASE)) u_ptr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .adv_i  (adv),
    .wrap_i (wrap),
    .ptr_o  (ptr)
  );

  tbd_byte_unpack #(.LW(LEN_W)) u_unpack (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .len_ld_i   (len_ld),
    .len_i      (len),
    .word_ld_i  (word_ld),
    .word_i     (mem_rdata_i),
    .step_i     (step),
    .byte_o     (tx_data_o),
    .first_o    (first),
    .last_o     (last),
    .word_end_o (word_end)
  );

  tbd_ctrl #(.AW(AW)) u_ctrl (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_halt_i  (clr_halt_i),
    .stop_req_i  (stop_req_i),
    .stop_clr_i  (stop_clr_i),
    .mem_rdata_i (mem_rdata_i),
    .ptr_i       (ptr),
    .last_i      (last),
    .word_end_i  (word_end),
    .mem_rd_en_o (mem_rd_en_o),
    .mem_wr_en_o (mem_wr_en_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .adv_o       (adv),
    .wrap_o      (wrap),
    .len_ld_o    (len_ld),
    .len_o       (len),
    .word_ld_o   (word_ld),
    .step_o      (step),
    .emit_o      (emit),
    .crc_o       (tx_crc_o),
    .done_o      (tx_done_o),
    .halted_o    (halted_o),
    .stop_done_o (stop_done_o)
  );

  assign tx_valid_o = emit;
  assign tx_sof_o   = emit & first;
  assign tx_eof_o   = emit & last;
endmodule

// File: rtl/tbd_tx_engine_chk.sv
module tbd_tx_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        clr_halt_i,
  input logic        stop_clr_i,
  input logic        mem_rd_en_o,
  input logic        mem_wr_en_o,
  input logic [31:0] mem_wdata_o,
  input logic        tx_valid_o,
  input logic        tx_sof_o,
  input logic        tx_eof_o,
  input logic        tx_done_o,
  input logic        halted_o,
  input logic        stop_done_o
);
  a_r2_halt_no_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halted_o && !clr_halt_i) |=> !mem_rd_en_o);
  a_r4_sof_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_sof_o |-> tx_valid_o);
  a_r4_eof_in_frame: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_eof_o |-> tx_valid_o);
  a_r5_wb_clears_ready: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_wr_en_o |-> (!mem_wdata_o[31] && !tx_valid_o));
  a_r6_done_with_wb: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |-> mem_wr_en_o);
  a_r6_done_single: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_done_o |=> !tx_done_o);
  a_r11_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_done_o && !stop_clr_i) |=> stop_done_o);
endmodule

bind tbd_tx_engine tbd_tx_engine_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_halt_i  (clr_halt_i),
  .stop_clr_i  (stop_clr_i),
  .mem_rd_en_o (mem_rd_en_o),
  .mem_wr_en_o (mem_wr_en_o),
  .mem_wdata_o (mem_wdata_o),
  .tx_valid_o  (tx_valid_o),
  .tx_sof_o    (tx_sof_o),
  .tx_eof_o    (tx_eof_o),
  .tx_done_o   (tx_done_o),
  .halted_o    (halted_o),
  .stop_done_o (stop_done_o)
);

// File: tb/tb_tbd_tx_engine.sv
`timescale 1ns/1ps
module tb_tbd_tx_engine;
  localparam int AW = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic clr_halt = 1'b0, stop_req = 1'b0, stop_clr = 1'b0;
  logic mem_rd_en, mem_wr_en;
  logic [AW-1:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic tx_valid, tx_sof, tx_eof, tx_crc, tx_done, halted, stop_done;
  logic [7:0] tx_data;

  always #2 clk = ~clk;

  tbd_tx_engine #(.AW(AW), .RING_BASE(0)) dut (
    .clk_i(clk), .rst_ni(rst_n), .clr_halt_i(clr_halt), .stop_req_i(stop_req),
    .stop_clr_i(stop_clr), .mem_rd_en_o(mem_rd_en), .mem_wr_en_o(mem_wr_en),
    .mem_addr_o(mem_addr), .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata),
    .tx_valid_o(tx_valid), .tx_data_o(tx_data), .tx_sof_o(tx_sof),
    .tx_eof_o(tx_eof), .tx_crc_o(tx_crc), .tx_done_o(tx_done),
    .halted_o(halted), .stop_done_o(stop_done)
  );

  logic [31:0] mem [1024];
  logic [31:0] posted [4];
  logic [10:0] exp_q[$];
  int checks = 0, errors = 0, done_exp = 0, done_seen = 0;

  always @(posedge clk) begin
    if (mem_rd_en) mem_rdata <= mem[mem_addr];
    if (mem_wr_en) mem[mem_addr] = mem_wdata;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  // reference stream: every clock, any valid byte must match the next expected one
  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R4 unexpected byte", int'(tx_data), -1);
        else begin
          logic [10:0] e;
          e = exp_q.pop_front();
          chk({tx_crc, tx_sof, tx_eof, tx_data} == e, "R4 byte/flags",
              int'({tx_crc, tx_sof, tx_eof, tx_data}), int'(e));
        end
      end else begin
        chk(!tx_sof && !tx_eof, "R4 marker without byte", int'({tx_sof, tx_eof}), 0);
      end
      if (tx_done) done_seen++;
    end
  end

  // fill a descriptor and its buffer; queue the expected bytes
  task automatic post(input int idx, input int len, input bit wrap, input bit irq,
                      input bit crc, input int seed);
    int bufw;
    bufw = 64 + 16 * idx;
    for (int k = 0; k < 16; k++) mem[bufw + k] = 32'h0;
    for (int k = 0; k < len; k++) begin
      logic [7:0] b;
      b = 8'((seed + k * 37) & 8'hFF);
      mem[bufw + k / 4][8 * (k % 4) +: 8] = b;
      exp_q.push_back({crc, k == 0, k == len - 1, b});
    end
    posted[idx] = {1'b1, wrap, irq, crc, 4'h5, 8'h3C, 16'(len)};
    mem[2 * idx + 1] = 32'(bufw);
    mem[2 * idx] = posted[idx];
    if (irq) done_exp++;
  endtask

  task automatic kick();
    clr_halt = 1'b1;
    @(negedge clk);
    clr_halt = 1'b0;
  endtask

  task automatic wait_halt(input string req);
    int n;
    n = 0;
    while (!halted && n < 2000) begin @(negedge clk); n++; end
    chk(halted, req, int'(halted), 1);
  endtask

  task automatic wb_ok(input int idx, input string req);
    chk(mem[2 * idx] == (posted[idx] & 32'h7FFF_FFFF), req,
        int'(mem[2 * idx]), int'(posted[idx] & 32'h7FFF_FFFF));
  endtask

  initial begin
    for (int k = 0; k < 1024; k++) mem[k] = 32'h0;
    mem[4] = 32'h4000_0000;  // desc2 not ready, wrap set
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(halted == 1'b1, "R1 halted", int'(halted), 1);
    chk(stop_done == 1'b0, "R1 stop_done", int'(stop_done), 0);
    chk(!tx_valid && !mem_rd_en && !mem_wr_en, "R1 idle", int'({tx_valid, mem_rd_en, mem_wr_en}), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!mem_rd_en && halted, "R2 no poll before clear", int'(mem_rd_en), 0);

    // R3 R4 R5 R8: two frames, halt at not-ready desc2
    post(0, 5, 1'b0, 1'b1, 1'b1, 11);
    post(1, 1, 1'b0, 1'b0, 1'b0, 90);
    kick();
    wait_halt("R8 halt on not ready");
    chk(exp_q.size() == 0, "R4 all bytes sent", exp_q.size(), 0);
    wb_ok(0, "R5 writeback desc0");
    wb_ok(1, "R5 writeback desc1");
    chk(mem[4] == 32'h4000_0000, "R5 no write to not-ready", int'(mem[4]), 32'h4000_0000);
    chk(done_seen == done_exp, "R6 done count", done_seen, done_exp);

    // R2: ready descriptor ignored while halted
    post(2, 7, 1'b1, 1'b1, 1'b0, 200);
    repeat (20) @(negedge clk);
    chk(exp_q.size() == 7 && mem[4][31], "R2 ignored while halted", exp_q.size(), 7);
    kick();
    wait_halt("R8 halt after wrap");
    wb_ok(2, "R5 writeback desc2");
    chk(exp_q.size() == 0, "R4 multiword frame", exp_q.size(), 0);
    // R7: next frame must come from descriptor 0
    post(0, 9, 1'b0, 1'b1, 1'b0, 3);
    kick();
    wait_halt("R8 halt at desc1");
    chk(exp_q.size() == 0, "R7 wrap to base", exp_q.size(), 0);
    wb_ok(0, "R7 desc0 reused");
    chk(done_seen == done_exp, "R6 done count", done_seen, done_exp);

    // R9 zero length
    post(1, 0, 1'b0, 1'b1, 1'b1, 0);
    kick();
    wait_halt("R9 halt");
    wb_ok(1, "R9 writeback");
    chk(done_seen == done_exp, "R9 done pulse", done_seen, done_exp);

    // R10 stop mid-frame
    post(2, 6, 1'b1, 1'b0, 1'b1, 77);
    post(0, 4, 1'b0, 1'b1, 1'b0, 150);
    kick();
    begin
      int n;
      n = 0;
      while (!tx_valid && n < 200) begin @(negedge clk); n++; end
    end
    stop_req = 1'b1;
    begin
      int n;
      n = 0;
      while (!stop_done && n < 200) begin @(negedge clk); n++; end
    end
    repeat (10) @(negedge clk);
    chk(stop_done, "R10 stop done", int'(stop_done), 1);
    chk(exp_q.size() == 4, "R10 frame finished, next not started", exp_q.size(), 4);
    chk(mem[0][31] == 1'b1, "R10 next desc untouched", int'(mem[0][31]), 1);
    stop_req = 1'b0;
    wait_halt("R10 resume");
    chk(exp_q.size() == 0, "R10 resumed frame", exp_q.size(), 0);
    chk(stop_done, "R11 sticky", int'(stop_done), 1);
    stop_clr = 1'b1; @(negedge clk); stop_clr = 1'b0;
    chk(!stop_done, "R11 cleared", int'(stop_done), 0);

    // R12 stop while halted, then clear-halt under request
    post(1, 2, 1'b0, 1'b0, 1'b0, 9);
    stop_req = 1'b1;
    repeat (3) @(negedge clk);
    chk(stop_done, "R10 stop while halted", int'(stop_done), 1);
    stop_clr = 1'b1; @(negedge clk); stop_clr = 1'b0;
    chk(stop_done, "R11 set wins under request", int'(stop_done), 1);
    kick();
    repeat (10) @(negedge clk);
    chk(exp_q.size() == 2 && mem[2][31], "R12 no fetch under stop", exp_q.size(), 2);
    stop_req = 1'b0;
    wait_halt("R12 resume");
    chk(exp_q.size() == 0, "R12 frame after release", exp_q.size(), 0);
    wb_ok(1, "R12 writeback");
    chk(done_seen == done_exp, "R6 final done count", done_seen, done_exp);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #400000;
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule